// File: doc/BRIEF.md
# Bit-Serial Trie Longest-Prefix Matcher

This block resolves a 32-bit destination address to a next hop by walking a binary prefix trie kept in an internal node memory. The walk starts at node 0 and consumes one address bit per clock, most significant bit first. Bit value 0 follows the left child and bit value 1 follows the right child. Whenever the walk passes a node that marks a stored prefix, that node's next hop becomes the running best match. When the walk ends, the deepest prefix seen is reported. If the path held no prefix at all, a configurable default hop is reported instead.

The trie is built elsewhere and loaded word by word through a synchronous write port while the block is idle. A lookup is started by pulsing the request valid input while the block is idle. One clock later the walk begins. A single-cycle done strobe marks the result, and the result then stays put until the next lookup completes.

Top module: `trie_lpm`

## Requirements
- R1: The walk starts at node 0. At walk depth d it tests address bit 31-d. A 0 moves to the left child and a 1 moves to the right child.
- R2: A walk visits at most 33 nodes, which means at most 32 bit tests. If a request is accepted at clock edge k and the walk visits N nodes, done is high in the cycle after edge k+N.
- R3: The result is the next hop of the deepest prefix-marked node on the visited path. A longer prefix overrides a shorter one that also covers the address.
- R4: If no visited node is prefix-marked, the result hop is the default hop sampled when the request was accepted, and the hit flag is 0. Otherwise the hit flag is 1.
- R5: The walk stops at the first node whose selected child is marked absent. A node at depth 32 also ends the walk.
- R6: done is high for exactly one cycle per lookup. The result hop and the hit flag change only in a cycle where done is high.
- R7: A request is accepted only while the block is idle. A request presented during a walk has no effect on that lookup's result or timing.
- R8: A node word is 19 bits wide: next hop [3:0], right-child index [9:4], left-child index [15:10], prefix-present bit 16, right-valid bit 17, left-valid bit 18. The word is stored at the clock edge where the write enable is high. Writes are issued only while no lookup is in progress.
- R9: After reset, done, the result hop and the hit flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Destination address to resolve |
| dflt_hop | input | 4 | Hop returned when no prefix matches |
| wr_en | input | 1 | Node memory write enable |
| wr_addr | input | 6 | Node index to write |
| wr_data | input | 19 | Node word (layout in R8) |
| res_hop | output | 4 | Resolved next hop |
| res_hit | output | 1 | 1 if a stored prefix matched, 0 if the default was used |
| done | output | 1 | One-cycle result strobe |

## Verification
The assertions rely on two things about the inputs. Node memory is never written while a walk is running, and every child index reachable from node 0 points at a node that was loaded beforehand. The stimulus meets both conditions. It loads each trie image completely before issuing lookups, and it only writes after the done strobe has come back. The bench also drives requests in the middle of a walk, to show that they are dropped and not queued.

// File: rtl/trie_lpm_pkg.sv
// Shared widths and the node word layout for the trie matcher.
// Assumes a binary trie with node 0 as root.
package trie_lpm_pkg;
    localparam int ADDR_W  = 32;
    localparam int IDX_W   = 6;
    localparam int HOP_W   = 4;
    localparam int NODES   = 1 << IDX_W;
    localparam int DEPTH_W = $clog2(ADDR_W + 1);

    // One trie node; the first member is the most significant field.
    typedef struct packed {
        logic             lvalid;
        logic             rvalid;
        logic             pfx;
        logic [IDX_W-1:0] lidx;
        logic [IDX_W-1:0] ridx;
        logic [HOP_W-1:0] hop;
    } node_t;

    localparam int NODE_W = $bits(node_t);
endpackage

// File: rtl/trie_node_ram.sv
// Node store: a synchronous write port and an asynchronous read port.
// Assumes writes happen only while no walk is in progress (busy low).
module trie_node_ram
    import trie_lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  node_t            wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output node_t            rd_data
);
    node_t mem [NODES];

    // Store one node word on the write edge.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Present the node that the walk is standing on.
    always_comb begin
        rd_data = mem[rd_addr];
    end

    // R8: the table must not be rewritten underneath a running walk.
    p_no_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy);
endmodule

// File: rtl/trie_walk_ctrl.sv
// Walk sequencer: takes a request while idle, steps one address bit per
// clock down the trie, tracks the deepest prefix seen and emits the result.
// Assumes rd_data holds the node at rd_idx in the same cycle.
module trie_walk_ctrl
    import trie_lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [HOP_W-1:0]  dflt_hop,
    input  node_t             rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              busy,
    output logic [HOP_W-1:0]  res_hop,
    output logic              res_hit,
    output logic              done
);
    typedef enum logic {S_IDLE, S_WALK} state_t;

    state_t              state_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [IDX_W-1:0]    node_q;
    logic [DEPTH_W-1:0]  depth_q;
    logic [HOP_W-1:0]    best_hop_q;
    logic                best_hit_q;

    logic [HOP_W-1:0]    best_hop_n;
    logic                best_hit_n;
    logic                take_right;
    logic                child_ok;
    logic [IDX_W-1:0]    child_idx;

    // Fold the current node into the running best and pick the next child.
    always_comb begin
        best_hop_n = rd_data.pfx ? rd_data.hop : best_hop_q;
        best_hit_n = rd_data.pfx | best_hit_q;
        take_right = addr_q[ADDR_W-1];
        child_idx  = take_right ? rd_data.ridx : rd_data.lidx;
        child_ok   = (depth_q < DEPTH_W'(ADDR_W)) &&
                     (take_right ? rd_data.rvalid : rd_data.lvalid);
    end

    assign rd_idx = node_q;
    assign busy   = (state_q == S_WALK);

    // Sequence the walk and register the result at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            addr_q     <= '0;
            node_q     <= '0;
            depth_q    <= '0;
            best_hop_q <= '0;
            best_hit_q <= 1'b0;
            res_hop    <= '0;
            res_hit    <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        state_q    <= S_WALK;
                        addr_q     <= req_addr;
                        node_q     <= '0;
                        depth_q    <= '0;
                        best_hop_q <= dflt_hop;
                        best_hit_q <= 1'b0;
                    end
                end
                S_WALK: begin
                    best_hop_q <= best_hop_n;
                    best_hit_q <= best_hit_n;
                    if (child_ok) begin
                        node_q  <= child_idx;
                        depth_q <= depth_q + 1'b1;
                        addr_q  <= addr_q << 1;
                    end else begin
                        state_q <= S_IDLE;
                        res_hop <= best_hop_n;
                        res_hit <= best_hit_n;
                        done    <= 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R2: depth never passes the address width during a walk.
    p_depth_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> depth_q <= DEPTH_W'(ADDR_W));

    // R6: done is a single-cycle strobe.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the result moves only together with done.
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({res_hop, res_hit}) |-> done);

    // R7: a walk starts only in response to a request.
    p_accept_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

// File: rtl/trie_lpm.sv
// Top of the trie longest-prefix matcher: the node store plus the walk
// sequencer. Assumes the trie image is loaded before lookups are issued.
module trie_lpm
    import trie_lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [HOP_W-1:0]  dflt_hop,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [NODE_W-1:0] wr_data,
    output logic [HOP_W-1:0]  res_hop,
    output logic              res_hit,
    output logic              done
);
    node_t            rd_data;
    logic [IDX_W-1:0] rd_idx;
    logic             busy;

    trie_node_ram u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (node_t'(wr_data)),
        .rd_addr (rd_idx),
        .rd_data (rd_data)
    );

    trie_walk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .dflt_hop  (dflt_hop),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .busy      (busy),
        .res_hop   (res_hop),
        .res_hit   (res_hit),
        .done      (done)
    );
endmodule

// File: tb/test_trie_lpm.sv
// Bench: behavioural reference walk over its own copy of the node table,
// compared with the outputs on every clock.
module test_trie_lpm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  dflt_hop = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [18:0] wr_data = '0;
    logic [3:0]  res_hop;
    logic        res_hit;
    logic        done;

    int compared = 0;
    int mismatched = 0;

    // Bench copy of the table contents, in plain integers.
    int m_lv[64], m_rv[64], m_pf[64], m_li[64], m_ri[64], m_hp[64];

    trie_lpm i_trie_lpm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .dflt_hop(dflt_hop), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .res_hop(res_hop), .res_hit(res_hit), .done(done)
    );

    always #4 clk = ~clk;

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_node(int idx, int lv, int rv, int pf, int li, int ri, int hp);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = idx[5:0];
        wr_data = {lv[0], rv[0], pf[0], li[5:0], ri[5:0], hp[3:0]};   // R8 layout
        m_lv[idx] = lv; m_rv[idx] = rv; m_pf[idx] = pf;
        m_li[idx] = li; m_ri[idx] = ri; m_hp[idx] = hp;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Reference: deepest prefix on the path, MSB first, node 0 root.
    task automatic ref_walk(logic [31:0] a, int dflt, output int hop, output int hit, output int steps);
        int n = 0;
        int d = 0;
        hop = dflt; hit = 0; steps = 0;
        forever begin
            steps++;
            if (m_pf[n] != 0) begin hop = m_hp[n]; hit = 1; end
            if (d == 32) break;
            if (a[31-d]) begin
                if (m_rv[n] == 0) break;
                n = m_ri[n];
            end else begin
                if (m_lv[n] == 0) break;
                n = m_li[n];
            end
            d++;
        end
    endtask

    // Issue one lookup; compare done and result on every clock.
    task automatic lookup(logic [31:0] a, int dflt, bit poke);
        int hop, hit, steps;
        int prev_hop, prev_hit;
        ref_walk(a, dflt, hop, hit, steps);
        prev_hop = res_hop; prev_hit = res_hit;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; dflt_hop = dflt[3:0];
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; dflt_hop = ~dflt[3:0];   // R4: sampled at acceptance
        check("R2 done low at start", done, 0);
        for (int c = 1; c <= steps; c++) begin
            if (poke && c == 1 && steps > 2) begin
                req_valid = 1'b1;   // R7: ignored while busy
                req_addr = ~a;
            end
            @(negedge clk);
            req_valid = 1'b0;
            check("R2 done timing", done, (c == steps) ? 1 : 0);
            if (c < steps) begin
                check("R6 result held", res_hop, prev_hop);
                check("R6 hit held", res_hit, prev_hit);
            end
        end
        check("R3 R5 result hop", res_hop, hop);
        check("R4 hit flag", res_hit, hit);
        @(negedge clk);
        check("R6 done single cycle", done, 0);
        check("R6 hop held after done", res_hop, hop);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_lv[i] = 0; m_rv[i] = 0; m_pf[i] = 0; m_li[i] = 0; m_ri[i] = 0; m_hp[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R9 reset done", done, 0);
        check("R9 reset hop", res_hop, 0);
        check("R9 reset hit", res_hit, 0);
        rst_n = 1'b1;

        // Eight-prefix image: 10*=1 111*=2 11001*=3 1*=4 0*=5 1000*=6 100000*=7 1000000*=8
        wr_node(0,  1, 1, 0, 1,  2,  0);
        wr_node(1,  0, 0, 1, 0,  0,  5);
        wr_node(2,  1, 1, 1, 3,  4,  4);
        wr_node(3,  1, 0, 1, 5,  0,  1);
        wr_node(4,  1, 1, 0, 6,  7,  0);
        wr_node(5,  1, 0, 0, 8,  0,  0);
        wr_node(6,  1, 0, 0, 9,  0,  0);
        wr_node(7,  0, 0, 1, 0,  0,  2);
        wr_node(8,  1, 0, 1, 10, 0,  6);
        wr_node(9,  0, 1, 0, 0,  11, 0);
        wr_node(10, 1, 0, 0, 12, 0,  0);
        wr_node(11, 0, 0, 1, 0,  0,  3);
        wr_node(12, 1, 0, 1, 13, 0,  7);
        wr_node(13, 0, 0, 1, 0,  0,  8);

        lookup(32'h0000_0000, 15, 0);   // R1: left branch, 0*
        lookup(32'hFFFF_FFFF, 15, 0);   // R5: stops at 111*
        lookup(32'hC800_0000, 15, 1);   // R3: 11001* beats 1*, with poke R7
        lookup(32'h8000_0000, 15, 1);   // R3: deepest 1000000*
        lookup(32'h8200_0000, 15, 0);   // R5: early stop keeps 100000*
        lookup(32'h8800_0000, 15, 0);   // R3: 1000*
        lookup(32'hA000_0000, 15, 0);   // R3: 10* overrides 1*
        lookup(32'hD000_0000, 15, 0);   // R3: falls back to 1*
        lookup(32'hC000_0000, 15, 1);   // R5: dead end under 1100

        // R4: empty root gives the default route
        wr_node(0, 0, 0, 0, 0, 0, 0);
        lookup(32'h1234_5678, 12, 0);
        lookup(32'h8000_0000, 3, 0);

        // R2: a 33-node chain down the left side, prefixes at depths 20 and 32
        for (int i = 0; i < 33; i++)
            wr_node(i, (i < 32) ? 1 : 0, 0, (i == 20 || i == 32) ? 1 : 0, i + 1, 0, (i == 20) ? 6 : 9);
        lookup(32'h0000_0000, 1, 1);   // R2: full 32 bit tests
        lookup(32'h0000_0001, 1, 0);   // R3: stops at depth 31, keeps depth-20 prefix
        lookup(32'h0010_0000, 2, 0);   // R4: stops at depth 11, no prefix yet

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule